// File: doc/BRIEF.md
# Dual-Channel Burst PWM Generator

This block drives two pulse-width-modulated outputs whose high and low times are set independently, in whole ticks of a 100 microsecond timebase. A prescaler inside the block divides the system clock down to that tick. Each channel either runs without end or emits a fixed number of high/low cycles and then stops by itself. A fixed burst length suits relay pulsing, stepper-style pulse trains and timed actuation.

Configuration arrives as single-cycle writes from a mailbox command processor. Each write carries an 8-bit command code and a 16-bit parameter. The code selects the channel's high time, low time or burst length, or the shared enable mask. Every setting can be read back combinationally through a separate code input, so the command processor can answer status queries without extra state.

A channel starts with its high phase when its enable bit is set. When a burst runs out, the channel clears its own enable bit. A period changed while a channel runs is picked up at the next phase boundary.

Top module: `burst_pwm_gen`

## Requirements
- R1: After reset both outputs are low, the enable mask reads 0, every high and low period reads 1, and every burst count reads 0.
- R2: A full high phase lasts (high value × TICK_DIV) clock cycles, and a full low phase lasts (low value × TICK_DIV) clock cycles. Only the first high phase after enabling may be shorter, because the prescaler runs freely.
- R3: A write to code 0x1F with bit n set sets the enable bit of idle channel n on the write's clock edge. On the following edge the channel drives its output high.
- R4: A write to code 0x1F with bit n clear drives output n low from the write's clock edge on.
- R5: With a nonzero burst count N, the channel produces exactly N high/low cycles. At the end of the Nth low phase it clears its own enable bit, and its output stays low afterwards.
- R6: A burst count of 0 makes the channel run until it is disabled, and its enable bit stays set.
- R7: A high or low period value of 0 behaves as a value of 1.
- R8: A period written while the channel runs leaves the phase in progress unchanged and applies from the next phase boundary.
- R9: Reading a high, low or burst code returns the stored value exactly as written, including 0. Reading 0x1F returns the enable mask in the low bits. Reading any other code returns 0. Writes to other codes change nothing.
- R10: Command codes: the high period of channel n is 0x10+2n, the low period of channel n is 0x11+2n, the burst count of channel n is 0x14+n, and the enable mask is 0x1F with bit n for channel n.
- R11: The burst count is latched when a channel starts. A burst write during a run affects only the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Configuration write strobe, one cycle per write |
| cmd_code | input | 8 | Command code of the write |
| cmd_param | input | DATA_W | Parameter of the write |
| rd_code | input | 8 | Code of the setting to read back |
| rd_data | output | DATA_W | Read-back value, combinational from rd_code |
| pwm_out | output | NUM_CH | PWM outputs, bit n for channel n |

## Verification
The bench builds the block with TICK_DIV = 3, NUM_CH = 2 and DATA_W = 16. With those values a whole burst of several cycles fits into a few dozen clocks, and phase widths become exact small numbers of clocks that the bench can check. With two channels it can run a finite burst next to a continuous channel, and it can retune one channel's period mid-run while the other finishes. A behavioural model follows the tick counter, phases, burst counts and mask on every clock, while a sweeping read code exercises every read-back code, including the undefined ones.

// File: rtl/burst_pwm_pkg.sv
package burst_pwm_pkg;

   localparam int unsigned CODE_W = 8;

   localparam logic [CODE_W-1:0] CODE_HI_BASE    = 8'h10;
   localparam logic [CODE_W-1:0] CODE_LO_BASE    = 8'h11;
   localparam logic [CODE_W-1:0] CODE_BURST_BASE = 8'h14;
   localparam logic [CODE_W-1:0] CODE_ENABLE     = 8'h1F;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIGH = 2'd1,
      PH_LOW  = 2'd2
   } phase_e;

   function automatic logic [CODE_W-1:0] code_hi(input int unsigned ch);
      return CODE_HI_BASE + CODE_W'(2 * ch);
   endfunction

   function automatic logic [CODE_W-1:0] code_lo(input int unsigned ch);
      return CODE_LO_BASE + CODE_W'(2 * ch);
   endfunction

   function automatic logic [CODE_W-1:0] code_burst(input int unsigned ch);
      return CODE_BURST_BASE + CODE_W'(ch);
   endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
   parameter int unsigned TICK_DIV = 20000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (TICK_DIV == 1) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_divide
         localparam int unsigned CNT_W = $clog2(TICK_DIV);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end

         assign tick = (cnt_q == CNT_LAST);
      end
   endgenerate

endmodule

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
   import burst_pwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned DATA_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_valid,
   input  logic [CODE_W-1:0]              wr_code,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [NUM_CH-1:0]              burst_done,
   input  logic [CODE_W-1:0]              rd_code,
   output logic [DATA_W-1:0]              rd_data,
   output logic [NUM_CH-1:0][DATA_W-1:0]  hi_val,
   output logic [NUM_CH-1:0][DATA_W-1:0]  lo_val,
   output logic [NUM_CH-1:0][DATA_W-1:0]  burst_val,
   output logic [NUM_CH-1:0]              en_mask
);

   localparam logic [DATA_W-1:0] PERIOD_RESET = DATA_W'(1);

   logic mask_wr;
   assign mask_wr = wr_valid && (wr_code == CODE_ENABLE);

   // enable mask: a mask write takes priority over a burst completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_mask <= '0;
      end else if (mask_wr) begin
         en_mask <= wr_data[NUM_CH-1:0];
      end else begin
         en_mask <= en_mask & ~burst_done;
      end
   end

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
         localparam logic [CODE_W-1:0] MY_HI = code_hi(gc);
         localparam logic [CODE_W-1:0] MY_LO = code_lo(gc);
         localparam logic [CODE_W-1:0] MY_BU = code_burst(gc);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_val[gc]    <= PERIOD_RESET;
               lo_val[gc]    <= PERIOD_RESET;
               burst_val[gc] <= '0;
            end else if (wr_valid) begin
               if (wr_code == MY_HI) hi_val[gc]    <= wr_data;
               if (wr_code == MY_LO) lo_val[gc]    <= wr_data;
               if (wr_code == MY_BU) burst_val[gc] <= wr_data;
            end
         end
      end
   endgenerate

   // combinational read-back
   always_comb begin
      rd_data = '0;
      if (rd_code == CODE_ENABLE) begin
         rd_data = DATA_W'(en_mask);
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_code == code_hi(c))    rd_data = hi_val[c];
         if (rd_code == code_lo(c))    rd_data = lo_val[c];
         if (rd_code == code_burst(c)) rd_data = burst_val[c];
      end
   end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import burst_pwm_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              enable,
   input  logic [DATA_W-1:0] hi_val,
   input  logic [DATA_W-1:0] lo_val,
   input  logic [DATA_W-1:0] burst_val,
   output logic              pwm,
   output logic              done
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   phase_e            phase_q;
   logic [DATA_W-1:0] rem_q;
   logic [DATA_W-1:0] cyc_q;
   logic [DATA_W-1:0] burst_q;

   logic [DATA_W-1:0] hi_eff;
   logic [DATA_W-1:0] lo_eff;
   logic              boundary;
   logic              last_cycle;

   // a zero period is stretched to one tick
   assign hi_eff = (hi_val == '0) ? ONE : hi_val;
   assign lo_eff = (lo_val == '0) ? ONE : lo_val;

   assign boundary   = tick && (rem_q == ONE);
   assign last_cycle = (burst_q != '0) && ((cyc_q + ONE) == burst_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         rem_q   <= '0;
         cyc_q   <= '0;
         burst_q <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (enable) begin
                  phase_q <= PH_HIGH;
                  rem_q   <= hi_eff;
                  cyc_q   <= '0;
                  burst_q <= burst_val;
               end
            end
            PH_HIGH: begin
               if (!enable) begin
                  phase_q <= PH_IDLE;
               end else if (boundary) begin
                  phase_q <= PH_LOW;
                  rem_q   <= lo_eff;
               end else if (tick) begin
                  rem_q <= rem_q - ONE;
               end
            end
            PH_LOW: begin
               if (!enable) begin
                  phase_q <= PH_IDLE;
               end else if (boundary) begin
                  if (last_cycle) begin
                     phase_q <= PH_IDLE;
                  end else begin
                     phase_q <= PH_HIGH;
                     rem_q   <= hi_eff;
                     cyc_q   <= cyc_q + ONE;
                  end
               end else if (tick) begin
                  rem_q <= rem_q - ONE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign pwm  = enable && (phase_q == PH_HIGH);
   assign done = enable && (phase_q == PH_LOW) && boundary && last_cycle;

endmodule

// File: rtl/burst_pwm_gen.sv
module burst_pwm_gen
   import burst_pwm_pkg::*;
#(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned TICK_DIV = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic [DATA_W-1:0] cmd_param,
   input  logic [7:0]        rd_code,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] pwm_out
);

   // the code map only leaves room for two channels below the burst codes
   generate
      if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_num_ch
         $error("burst_pwm_gen: NUM_CH must be 1 or 2");
      end
      if (DATA_W < NUM_CH || DATA_W > 16) begin : g_bad_data_w
         $error("burst_pwm_gen: DATA_W must lie between NUM_CH and 16");
      end
      if (TICK_DIV < 1) begin : g_bad_tick_div
         $error("burst_pwm_gen: TICK_DIV must be at least 1");
      end
   endgenerate

   logic                          tick;
   logic [NUM_CH-1:0]             en_mask;
   logic [NUM_CH-1:0]             burst_done;
   logic [NUM_CH-1:0][DATA_W-1:0] hi_val;
   logic [NUM_CH-1:0][DATA_W-1:0] lo_val;
   logic [NUM_CH-1:0][DATA_W-1:0] burst_val;

   pwm_tick_gen #(
      .TICK_DIV (TICK_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   pwm_cfg_bank #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (cmd_valid),
      .wr_code    (cmd_code),
      .wr_data    (cmd_param),
      .burst_done (burst_done),
      .rd_code    (rd_code),
      .rd_data    (rd_data),
      .hi_val     (hi_val),
      .lo_val     (lo_val),
      .burst_val  (burst_val),
      .en_mask    (en_mask)
   );

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CH; gc++) begin : g_chan
         pwm_channel #(
            .DATA_W (DATA_W)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .enable    (en_mask[gc]),
            .hi_val    (hi_val[gc]),
            .lo_val    (lo_val[gc]),
            .burst_val (burst_val[gc]),
            .pwm       (pwm_out[gc]),
            .done      (burst_done[gc])
         );
      end
   endgenerate

endmodule

// File: rtl/burst_pwm_chk.sv
module burst_pwm_chk
   import burst_pwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [7:0]        cmd_code,
   input logic [DATA_W-1:0] cmd_param,
   input logic [7:0]        rd_code,
   input logic [DATA_W-1:0] rd_data,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [NUM_CH-1:0] en_mask
);

   logic mask_wr;
   logic code_known;

   assign mask_wr = cmd_valid && (cmd_code == CODE_ENABLE);

   always_comb begin
      code_known = (rd_code == CODE_ENABLE);
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_code == 8'(8'h10 + 2 * c) || rd_code == 8'(8'h11 + 2 * c) ||
             rd_code == 8'(8'h14 + c))
            code_known = 1'b1;
      end
   end

   // R9: undefined read codes return zero
   a_r9_unknown_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !code_known |-> (rd_data == '0));

   // R10: a mask write lands in the enable mask on its own edge
   a_r10_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (en_mask == $past(cmd_param[NUM_CH-1:0])));

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
         // R4: clearing an enable bit silences the output at once
         a_r4_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_wr && !cmd_param[gc]) |=> !pwm_out[gc]);

         // R3: a newly set enable bit starts with a high phase
         a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_mask[gc]) |=> (pwm_out[gc] || !en_mask[gc]));

         // R5: a self-cleared enable bit only follows a low phase
         a_r5_stop_after_low: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(en_mask[gc]) && !$past(mask_wr)) |-> !$past(pwm_out[gc]));
      end
   endgenerate

endmodule

bind burst_pwm_gen burst_pwm_chk #(
   .NUM_CH (NUM_CH),
   .DATA_W (DATA_W)
) u_burst_pwm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_code  (cmd_code),
   .cmd_param (cmd_param),
   .rd_code   (rd_code),
   .rd_data   (rd_data),
   .pwm_out   (pwm_out),
   .en_mask   (en_mask)
);

// File: tb/test_burst_pwm_gen.sv
`timescale 1ns/1ps
module test_burst_pwm_gen;

   localparam int NCH  = 2;
   localparam int DW   = 16;
   localparam int TDIV = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_code = '0;
   logic [DW-1:0] cmd_param = '0;
   logic [7:0]    rd_code = '0;
   logic [DW-1:0] rd_data;
   logic [NCH-1:0] pwm_out;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   bit cmp_on = 0;
   bit sweep = 0;

   always #2.5 clk = ~clk;

   burst_pwm_gen #(
      .NUM_CH   (NCH),
      .DATA_W   (DW),
      .TICK_DIV (TDIV)
   ) i_burst_pwm_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .cmd_param (cmd_param),
      .rd_code   (rd_code),
      .rd_data   (rd_data),
      .pwm_out   (pwm_out)
   );

   // ---------------- behavioural reference ----------------
   int m_pc;
   int m_ph[NCH];
   int m_rem[NCH];
   int m_cyc[NCH];
   int m_bl[NCH];
   int m_hi[NCH];
   int m_lo[NCH];
   int m_bu[NCH];
   int m_en;

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pc = 0;
         m_en = 0;
         for (int c = 0; c < NCH; c++) begin
            m_ph[c] = 0; m_rem[c] = 0; m_cyc[c] = 0; m_bl[c] = 0;
            m_hi[c] = 1; m_lo[c] = 1; m_bu[c] = 0;
         end
      end else begin
         bit tk;
         int done_v;
         tk = (m_pc == TDIV - 1);
         m_pc = tk ? 0 : m_pc + 1;
         done_v = 0;
         for (int c = 0; c < NCH; c++) begin
            bit on;
            on = m_en[c];
            case (m_ph[c])
               0: if (on) begin
                     m_ph[c] = 1; m_rem[c] = eff(m_hi[c]); m_cyc[c] = 0; m_bl[c] = m_bu[c];
                  end
               1: if (!on) m_ph[c] = 0;
                  else if (tk) begin
                     if (m_rem[c] == 1) begin m_ph[c] = 2; m_rem[c] = eff(m_lo[c]); end
                     else m_rem[c]--;
                  end
               default: if (!on) m_ph[c] = 0;
                  else if (tk) begin
                     if (m_rem[c] == 1) begin
                        if (m_bl[c] != 0 && m_cyc[c] + 1 == m_bl[c]) begin
                           m_ph[c] = 0; done_v |= (1 << c);
                        end else begin
                           m_ph[c] = 1; m_rem[c] = eff(m_hi[c]); m_cyc[c]++;
                        end
                     end else m_rem[c]--;
                  end
            endcase
         end
         if (cmd_valid && cmd_code == 8'h1F) m_en = int'(cmd_param) & ((1 << NCH) - 1);
         else m_en = m_en & ~done_v;
         if (cmd_valid) begin
            for (int c = 0; c < NCH; c++) begin
               if (int'(cmd_code) == 16 + 2 * c) m_hi[c] = int'(cmd_param);
               if (int'(cmd_code) == 17 + 2 * c) m_lo[c] = int'(cmd_param);
               if (int'(cmd_code) == 20 + c)     m_bu[c] = int'(cmd_param);
            end
         end
      end
   end

   function automatic int model_rd(input int code);
      int r;
      r = 0;
      if (code == 31) r = m_en;
      for (int c = 0; c < NCH; c++) begin
         if (code == 16 + 2 * c) r = m_hi[c];
         if (code == 17 + 2 * c) r = m_lo[c];
         if (code == 20 + c)     r = m_bu[c];
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always begin
      @(negedge clk);
      #1;
      if (cmp_on && rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            int e;
            e = (m_en[c] && m_ph[c] == 1) ? 1 : 0;
            check(int'(pwm_out[c]) == e, "R2", $sformatf("model pwm ch%0d", c),
                  int'(pwm_out[c]), e);
         end
         check(int'(rd_data) == model_rd(int'(rd_code)), "R9",
               $sformatf("model readback code %0d", rd_code),
               int'(rd_data), model_rd(int'(rd_code)));
         if (sweep) rd_code = rd_code + 8'd1;
      end
   end

   // pulse width monitor
   int hw[NCH][$];
   int lw[NCH][$];
   int run[NCH];
   logic [NCH-1:0] prev_pwm = '0;

   always @(negedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (pwm_out[c] == prev_pwm[c]) run[c]++;
         else begin
            if (prev_pwm[c]) hw[c].push_back(run[c]);
            else lw[c].push_back(run[c]);
            run[c] = 1;
         end
      end
      prev_pwm = pwm_out;
   end

   task automatic clear_mon();
      for (int c = 0; c < NCH; c++) begin
         hw[c].delete();
         lw[c].delete();
         run[c] = 0;
      end
   endtask

   task automatic wr(input logic [7:0] code, input logic [DW-1:0] val);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = code; cmd_param = val;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = '0; cmd_param = '0;
   endtask

   task automatic rd(input logic [7:0] code, output int val);
      sweep = 0;
      @(negedge clk);
      #2;
      rd_code = code;
      #1;
      val = int'(rd_data);
   endtask

   // watchdog
   int cyc_cnt = 0;
   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 100000 && !finished) begin
         finished = 1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc_cnt);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      cmp_on = 1;

      // R1: reset state
      rd(8'h10, v); check(v == 1, "R1", "ch0 high after reset", v, 1);
      rd(8'h13, v); check(v == 1, "R1", "ch1 low after reset", v, 1);
      rd(8'h14, v); check(v == 0, "R1", "ch0 burst after reset", v, 0);
      rd(8'h1F, v); check(v == 0, "R1", "mask after reset", v, 0);
      check(pwm_out == '0, "R1", "outputs after reset", int'(pwm_out), 0);

      // configuration through the code map (R10)
      wr(8'h10, 16'd2);
      wr(8'h11, 16'd3);
      wr(8'h14, 16'd3);
      wr(8'h12, 16'd0);
      wr(8'h13, 16'd1);
      wr(8'h15, 16'd0);
      wr(8'h16, 16'h0055);
      rd(8'h16, v); check(v == 0, "R9", "undefined code reads zero", v, 0);
      rd(8'h12, v); check(v == 0, "R9", "zero period reads back raw", v, 0);
      rd(8'h14, v); check(v == 3, "R10", "ch0 burst at 0x14", v, 3);
      rd(8'h11, v); check(v == 3, "R10", "ch0 low at 0x11", v, 3);
      sweep = 1;
      repeat (40) @(negedge clk);

      // R3: enable both channels
      clear_mon();
      wr(8'h1F, 16'h0003);
      check(pwm_out == '0, "R3", "output one edge after enable", int'(pwm_out), 0);
      @(negedge clk);
      check(pwm_out == 2'b11, "R3", "output two edges after enable", int'(pwm_out), 3);

      // R11: burst change during the run must not shorten it
      wr(8'h14, 16'd1);

      // wait for the ch0 burst to end
      for (int i = 0; i < 600; i++) begin
         rd(8'h1F, v);
         if (v[0] == 1'b0) break;
      end
      rd(8'h1F, v); check(v == 2, "R5", "ch0 self-cleared, ch1 still on", v, 2);
      check(hw[0].size() == 3, "R5", "ch0 high pulse count (R11 latched burst)",
            hw[0].size(), 3);
      if (hw[0].size() > 1) check(hw[0][1] == 2 * TDIV, "R2", "ch0 full high width", hw[0][1], 2 * TDIV);
      if (lw[0].size() > 1) check(lw[0][1] == 3 * TDIV, "R2", "ch0 full low width", lw[0][1], 3 * TDIV);
      if (hw[1].size() > 1) check(hw[1][1] == TDIV, "R7", "ch1 zero high acts as one", hw[1][1], TDIV);
      if (lw[1].size() > 1) check(lw[1][1] == TDIV, "R7", "ch1 low width one tick", lw[1][1], TDIV);
      repeat (30) @(negedge clk);
      check(pwm_out[0] == 1'b0, "R5", "ch0 stays low after burst", int'(pwm_out[0]), 0);

      // R8: retune ch1 while running
      wr(8'h12, 16'd4);
      repeat (60) @(negedge clk);
      check(hw[1].size() > 0 && hw[1][$] == 4 * TDIV, "R8", "ch1 new high width",
            (hw[1].size() > 0) ? hw[1][$] : -1, 4 * TDIV);
      rd(8'h1F, v); check(v[1] == 1'b1, "R6", "ch1 continuous run keeps enable", v, 2);
      check(hw[1].size() > 5, "R6", "ch1 pulse count beyond a burst", hw[1].size(), 6);

      // R4: disable mid high phase
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (pwm_out[1]) break;
      end
      wr(8'h1F, 16'h0000);
      check(pwm_out == '0, "R4", "output low right after disable", int'(pwm_out), 0);
      rd(8'h1F, v); check(v == 0, "R4", "mask after disable", v, 0);
      repeat (10) @(negedge clk);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule